// File: doc/BRIEF.md
# Serial/Parallel RAM Bus Arbiter

This block decides which of two masters talks to a single external SRAM: a host on a bytewide parallel bus, or an internal serial-to-parallel converter. A serial select line picks the owner. While that line is low the host's address, active-low strobes and write data reach the RAM. While it is high the converter's do instead, and the host is cut off.

The data lines are modelled as separate input, output and output-enable signals on each side. The direction of each enable is worked out from the owning master's active-low strobe combination. There is no explicit direction bit. A write is chip-enable plus write-enable low. A read is chip-enable plus output-enable low with write-enable high. Any other combination drives nothing.

Ownership is registered. On the clock edge after the select line changes, the owner switches and the RAM strobes are held inactive for that one cycle, so a write cannot glitch through. The data paths carry no valid/ready handshake and no back-pressure. The RAM is asynchronous and level-strobed, so each master must hold its strobes for as long as it needs the cycle.

Top module: `ram_bus_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released until the first rising clock edge, the RAM strobes read high and both data output enables read low.
- R2: When the select line has been low for at least two edges, `ram_addr` equals `host_addr`, and the RAM strobes follow the host strobes, except as stated in R5. Converter strobes have no effect.
- R3: When the select line has been high for at least two edges, `ram_addr` equals `cvt_addr` and the RAM strobes follow the converter strobes, except as stated in R5. `cvt_dq_o` always equals `ram_dq_i`.
- R4: A write is decoded when the owner's chip-enable and write-enable are both 0. Then `ram_dq_oe` is 1, `ram_dq_o` carries the owner's write data, and `host_dq_oe` is 0.
- R5: During a decoded write the owner's output-enable is ignored, and `ram_oe_n` reads 1 even when that output-enable is 0.
- R6: A host read is decoded when the host owns the bus and chip-enable = 0, output-enable = 0 and write-enable = 1. Then `host_dq_oe` is 1, `host_dq_o` equals `ram_dq_i`, and `ram_dq_oe` is 0.
- R7: When neither read nor write is decoded (for example chip-enable = 1), both `ram_dq_oe` and `host_dq_oe` are 0.
- R8: While the converter owns the bus, `host_dq_oe` is 0 and host strobes do not reach the RAM.
- R9: The owner changes on the first rising edge after the select line changes. For that one cycle all three RAM strobes are 1 and both output enables are 0. Before that edge the previous owner still drives the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel | input | 1 | Serial select: 1 gives the RAM to the converter |
| host_addr | input | ADDR_W | Host address |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_oe_n | input | 1 | Host output-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| host_dq_i | input | DATA_W | Host write data |
| host_dq_o | output | DATA_W | Read data toward the host |
| host_dq_oe | output | 1 | Drive enable for the host data lines |
| cvt_addr | input | ADDR_W | Converter address |
| cvt_ce_n | input | 1 | Converter chip-enable, active low |
| cvt_oe_n | input | 1 | Converter output-enable, active low |
| cvt_we_n | input | 1 | Converter write-enable, active low |
| cvt_dq_i | input | DATA_W | Converter write data |
| cvt_dq_o | output | DATA_W | Read data toward the converter |
| ram_addr | output | ADDR_W | RAM address |
| ram_ce_n | output | 1 | RAM chip-enable, active low |
| ram_oe_n | output | 1 | RAM output-enable, active low |
| ram_we_n | output | 1 | RAM write-enable, active low |
| ram_dq_i | input | DATA_W | Data returned by the RAM |
| ram_dq_o | output | DATA_W | Data driven to the RAM |
| ram_dq_oe | output | 1 | Drive enable for the RAM data lines |

## Verification
The bench holds a write on the bus while ownership changes, in both directions.

- If the blanking cycle were missing, a write strobe would reach the RAM with the new owner's address.
- If the owner switched combinationally, the old owner would lose the bus before the edge.

It drives write-enable and output-enable low together to catch a design that lets both data sides drive, or passes output-enable to the RAM during a write. It also attempts host reads and writes while the converter owns the bus, which exposes a decoder that is not qualified by ownership. The first cycle after reset release is checked as well, to catch a design that leaves the strobes active.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;

  typedef enum logic {
    OWN_HOST   = 1'b0,
    OWN_SERIAL = 1'b1
  } owner_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } strobe_t;

  typedef struct packed {
    logic rd;
    logic wr;
  } cyc_t;

  localparam strobe_t STB_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/arb_owner_ctrl.sv
module arb_owner_ctrl
  import ram_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ser_sel,
  output owner_e own_q,
  output logic   blank_q
);

  owner_e own_d;

  always_comb begin
    own_d = ser_sel ? OWN_SERIAL : OWN_HOST;
  end

  // A blank cycle follows every change of owner, and reset leaves one pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= OWN_HOST;
      blank_q <= 1'b1;
    end else begin
      own_q   <= own_d;
      blank_q <= (own_d != own_q);
    end
  end

endmodule

// File: rtl/arb_cycle_decode.sv
module arb_cycle_decode
  import ram_arb_pkg::*;
(
  input  strobe_t stb,
  output cyc_t    cyc,
  output strobe_t stb_eff
);

  always_comb begin
    cyc.wr = ~stb.ce_n & ~stb.we_n;
    cyc.rd = ~stb.ce_n & ~stb.oe_n & stb.we_n;
    stb_eff      = stb;
    // Output-enable carries no meaning while a write is in progress.
    stb_eff.oe_n = stb.oe_n | cyc.wr;
  end

endmodule

// File: rtl/arb_bus_mux.sv
module arb_bus_mux
  import ram_arb_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  owner_e              own,
  input  logic                blank,
  input  logic [ADDR_W-1:0]   addr_h,
  input  logic [ADDR_W-1:0]   addr_c,
  input  strobe_t             stb_h,
  input  strobe_t             stb_c,
  input  cyc_t                cyc_h,
  input  cyc_t                cyc_c,
  input  logic [DATA_W-1:0]   wdat_h,
  input  logic [DATA_W-1:0]   wdat_c,
  output logic [ADDR_W-1:0]   addr_r,
  output strobe_t             stb_r,
  output logic [DATA_W-1:0]   wdat_r,
  output logic                ram_drive,
  output logic                host_drive
);

  logic    sel_c;
  strobe_t stb_sel;
  cyc_t    cyc_sel;

  always_comb begin
    sel_c   = (own == OWN_SERIAL);
    addr_r  = sel_c ? addr_c : addr_h;
    wdat_r  = sel_c ? wdat_c : wdat_h;
    stb_sel = sel_c ? stb_c  : stb_h;
    cyc_sel = sel_c ? cyc_c  : cyc_h;
    if (blank) begin
      stb_r      = STB_IDLE;
      ram_drive  = 1'b0;
      host_drive = 1'b0;
    end else begin
      stb_r      = stb_sel;
      ram_drive  = cyc_sel.wr;
      host_drive = ~sel_c & cyc_h.rd;
    end
  end

endmodule

// File: rtl/ram_bus_arbiter.sv
module ram_bus_arbiter
  import ram_arb_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_ce_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  input  logic [DATA_W-1:0] host_dq_i,
  output logic [DATA_W-1:0] host_dq_o,
  output logic              host_dq_oe,
  input  logic [ADDR_W-1:0] cvt_addr,
  input  logic              cvt_ce_n,
  input  logic              cvt_oe_n,
  input  logic              cvt_we_n,
  input  logic [DATA_W-1:0] cvt_dq_i,
  output logic [DATA_W-1:0] cvt_dq_o,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe
);

  localparam int NUM_MST = 2;
  localparam int MST_H   = 0;
  localparam int MST_C   = 1;

  owner_e  own_q;
  logic    blank_q;
  strobe_t stb_raw [NUM_MST];
  strobe_t stb_eff [NUM_MST];
  cyc_t    cyc     [NUM_MST];
  strobe_t stb_ram;

  always_comb begin
    stb_raw[MST_H] = '{ce_n: host_ce_n, oe_n: host_oe_n, we_n: host_we_n};
    stb_raw[MST_C] = '{ce_n: cvt_ce_n,  oe_n: cvt_oe_n,  we_n: cvt_we_n};
  end

  arb_owner_ctrl u_own (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_sel (ser_sel),
    .own_q   (own_q),
    .blank_q (blank_q)
  );

  for (genvar g = 0; g < NUM_MST; g++) begin : g_dec
    arb_cycle_decode u_dec (
      .stb     (stb_raw[g]),
      .cyc     (cyc[g]),
      .stb_eff (stb_eff[g])
    );
  end

  arb_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .own        (own_q),
    .blank      (blank_q),
    .addr_h     (host_addr),
    .addr_c     (cvt_addr),
    .stb_h      (stb_eff[MST_H]),
    .stb_c      (stb_eff[MST_C]),
    .cyc_h      (cyc[MST_H]),
    .cyc_c      (cyc[MST_C]),
    .wdat_h     (host_dq_i),
    .wdat_c     (cvt_dq_i),
    .addr_r     (ram_addr),
    .stb_r      (stb_ram),
    .wdat_r     (ram_dq_o),
    .ram_drive  (ram_dq_oe),
    .host_drive (host_dq_oe)
  );

  always_comb begin
    ram_ce_n  = stb_ram.ce_n;
    ram_oe_n  = stb_ram.oe_n;
    ram_we_n  = stb_ram.we_n;
    host_dq_o = ram_dq_i;
    cvt_dq_o  = ram_dq_i;
  end

endmodule

// File: rtl/ram_bus_arbiter_chk.sv
module ram_bus_arbiter_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_sel,
  input logic [ADDR_W-1:0] host_addr,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              ram_dq_oe,
  input logic              host_dq_oe,
  input logic              own_q
);

  AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_dq_oe && host_dq_oe)); // R7

  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n && !ram_ce_n |-> ram_oe_n); // R5

  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_we_n && !ram_ce_n)); // R4

  AST_SERIAL_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    own_q |-> !host_dq_oe); // R8

  AST_SWITCH_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q != $past(own_q)) |-> (ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_oe && !host_dq_oe)); // R9

  AST_HOST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel && !$past(ser_sel) && !own_q) |-> (ram_addr == host_addr)); // R2

endmodule

bind ram_bus_arbiter ram_bus_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_sel    (ser_sel),
  .host_addr  (host_addr),
  .ram_addr   (ram_addr),
  .ram_ce_n   (ram_ce_n),
  .ram_oe_n   (ram_oe_n),
  .ram_we_n   (ram_we_n),
  .ram_dq_oe  (ram_dq_oe),
  .host_dq_oe (host_dq_oe),
  .own_q      (own_q)
);

// File: tb/ram_bus_arbiter_tb.sv
`timescale 1ns/1ps
module ram_bus_arbiter_tb;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam logic [AW-1:0] HADDR = 19'h5A5A5;
  localparam logic [AW-1:0] CADDR = 19'h2C3D1;
  localparam logic [DW-1:0] HDAT  = 8'hA7;
  localparam logic [DW-1:0] CDAT  = 8'h3C;
  localparam logic [DW-1:0] RDAT  = 8'h96;

  // {sel, h_ce, h_oe, h_we, c_ce, c_oe, c_we, e_ce, e_oe, e_we, e_ram_oe, e_host_oe}
  localparam int NV = 11;
  localparam logic [11:0] VEC [NV] = '{
    12'b0_111_000_111_00,  // host idle, converter strobes ignored
    12'b0_010_111_010_10,  // host write
    12'b0_000_111_010_10,  // host write with oe low
    12'b0_001_111_001_01,  // host read
    12'b0_101_111_101_00,  // oe without ce
    12'b0_110_111_110_00,  // we without ce
    12'b1_001_111_111_00,  // serial idle, host read ignored
    12'b1_000_010_010_10,  // serial write
    12'b1_111_000_010_10,  // serial write with oe low
    12'b1_001_001_001_00,  // serial read
    12'b0_001_000_001_01   // host read after return
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel = 1'b0;
  logic [AW-1:0] host_addr = HADDR;
  logic host_ce_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
  logic [DW-1:0] host_dq_i = HDAT;
  logic [DW-1:0] host_dq_o;
  logic host_dq_oe;
  logic [AW-1:0] cvt_addr = CADDR;
  logic cvt_ce_n = 1'b1, cvt_oe_n = 1'b1, cvt_we_n = 1'b1;
  logic [DW-1:0] cvt_dq_i = CDAT;
  logic [DW-1:0] cvt_dq_o;
  logic [AW-1:0] ram_addr;
  logic ram_ce_n, ram_oe_n, ram_we_n;
  logic [DW-1:0] ram_dq_i = RDAT;
  logic [DW-1:0] ram_dq_o;
  logic ram_dq_oe;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ram_bus_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel),
    .host_addr(host_addr), .host_ce_n(host_ce_n), .host_oe_n(host_oe_n),
    .host_we_n(host_we_n), .host_dq_i(host_dq_i), .host_dq_o(host_dq_o),
    .host_dq_oe(host_dq_oe), .cvt_addr(cvt_addr), .cvt_ce_n(cvt_ce_n),
    .cvt_oe_n(cvt_oe_n), .cvt_we_n(cvt_we_n), .cvt_dq_i(cvt_dq_i),
    .cvt_dq_o(cvt_dq_o), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_dq_i(ram_dq_i),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 4, 5: return "R7";
      1:       return "R4";
      2, 8:    return "R5";
      3, 10:   return "R6";
      6:       return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic set_h(input logic [2:0] s);
    {host_ce_n, host_oe_n, host_we_n} = s;
  endtask

  task automatic set_c(input logic [2:0] s);
    {cvt_ce_n, cvt_oe_n, cvt_we_n} = s;
  endtask

  task automatic strobes(input string req, input logic [2:0] e, input logic rdo, input logic hdo);
    chk(req, "ram strobes", {29'd0, ram_ce_n, ram_oe_n, ram_we_n}, {29'd0, e});
    chk(req, "ram_dq_oe", {31'd0, ram_dq_oe}, {31'd0, rdo});
    chk(req, "host_dq_oe", {31'd0, host_dq_oe}, {31'd0, hdo});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    // R1: reset state with a host write requested
    set_h(3'b010);
    repeat (3) @(negedge clk);
    strobes("R1", 3'b111, 1'b0, 1'b0);
    rst_n = 1'b1;
    #1;
    strobes("R1", 3'b111, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R4", "write after reset", {29'd0, ram_ce_n, ram_oe_n, ram_we_n}, {29'd0, 3'b010});

    // table of steady-state vectors
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      @(negedge clk);
      ser_sel = v[11];
      set_h(v[10:8]);
      set_c(v[7:5]);
      repeat (2) @(posedge clk);
      @(negedge clk);
      strobes(vtag(i), v[4:2], v[1], v[0]);
      chk(v[11] ? "R3" : "R2", "ram_addr", {13'd0, ram_addr}, {13'd0, (v[11] ? CADDR : HADDR)});
      chk("R3", "cvt_dq_o", {24'd0, cvt_dq_o}, {24'd0, RDAT});
      if (v[1]) chk("R4", "ram_dq_o", {24'd0, ram_dq_o}, {24'd0, (v[11] ? CDAT : HDAT)});
      if (v[0]) chk("R6", "host_dq_o", {24'd0, host_dq_o}, {24'd0, RDAT});
    end

    // R9: switch host -> serial with writes held on both sides
    @(negedge clk);
    ser_sel = 1'b0; set_h(3'b010); set_c(3'b010);
    repeat (2) @(posedge clk);
    @(negedge clk);
    ser_sel = 1'b1;
    #1;
    chk("R9", "old owner before edge", {13'd0, ram_addr}, {13'd0, HADDR});
    chk("R9", "old write before edge", {31'd0, ram_we_n}, 32'd0);
    @(negedge clk);
    strobes("R9", 3'b111, 1'b0, 1'b0);
    chk("R9", "new owner addr", {13'd0, ram_addr}, {13'd0, CADDR});
    @(negedge clk);
    strobes("R9", 3'b010, 1'b1, 1'b0);
    chk("R4", "serial wdata", {24'd0, ram_dq_o}, {24'd0, CDAT});

    // R9: switch serial -> host with a host read pending
    set_h(3'b001);
    #1;
    strobes("R8", 3'b010, 1'b1, 1'b0);
    ser_sel = 1'b0;
    @(negedge clk);
    strobes("R9", 3'b111, 1'b0, 1'b0);
    @(negedge clk);
    strobes("R6", 3'b001, 1'b0, 1'b1);

    // R9: a one-cycle pulse on the select line blanks twice
    ser_sel = 1'b1;
    @(negedge clk);
    ser_sel = 1'b0;
    strobes("R9", 3'b111, 1'b0, 1'b0);
    @(negedge clk);
    strobes("R9", 3'b111, 1'b0, 1'b0);
    @(negedge clk);
    strobes("R2", 3'b001, 1'b0, 1'b1);

    // R1: reset in mid-operation
    rst_n = 1'b0;
    #1;
    strobes("R1", 3'b111, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    strobes("R6", 3'b001, 1'b0, 1'b1);

    summary();
  end

endmodule